// File: doc/BRIEF.md
# Four-Mode Serial Port

This block is a full-duplex serial port. It has one shift engine for each direction, a control byte and a receive holding byte. Both bytes sit behind a two-address register window. Software picks one of four framings: a clocked 8-bit shift register, a 10-bit asynchronous frame, and two 11-bit asynchronous frames. The 11-bit frames carry a programmable ninth bit. Writing the data address launches a transmission. Reading the data address returns the most recently accepted received byte.

The asynchronous framings use a 16x oversampling tick. In the fixed-rate 11-bit framing the tick comes from the core clock. In the other two asynchronous framings it comes from an external timer overflow pulse. A rate-doubling input halves the bit period in all three asynchronous framings. The receiver watches for a falling edge on the line and confirms the start bit at its midpoint. It then samples every later bit at its centre. An address-filter option in the 11-bit framings drops frames whose ninth bit is 0, so that several receivers on a shared line wake only on address frames. The done flags are set by hardware and cleared only by a software write to the control byte.

Top module: `quad_serial_port`

## Requirements
- R1: While reset is held and after it: control byte 0x00, receive byte 0x00, `tx_line` high, `sclk_o` high, `sdat_oe` low.
- R2: The control byte (`bus_sel`=0) has these fields:
  - [7:6] framing: 0 shift, 1 ten-bit, 2 eleven-bit fixed rate, 3 eleven-bit timer rate
  - [5] address filter
  - [4] receive enable
  - [3] transmit ninth bit
  - [2] received ninth bit
  - [1] transmit done
  - [0] receive done
- R3: In framing 0, a data write drives the 8 bits LSB first on `sdat_o` with `sdat_oe` high. Each bit lasts 12 clocks, `sclk_o` is low for its first 6 clocks and high for its last 6, and transmit done is set after the eighth bit.
- R4: In framing 0, with receive enable=1 and receive done=0, the port generates 8 `sclk_o` periods. It samples `rx_line` late in each high phase, assembles the bits LSB first, loads the receive byte and sets receive done.
- R5: Framing 1 transmits start (0), 8 data bits LSB first, then stop (1). The transmit ninth bit is not used.
- R6: Framings 2 and 3 transmit start, 8 data bits LSB first, the transmit ninth bit, then stop.
- R7: A bit lasts 16 ticks. In framing 2 the bit period is 64 clocks, or 32 clocks with `dbl_rate`=1. In framings 1 and 3 a tick is every second `tmr_ovf` pulse, or every pulse with `dbl_rate`=1.
- R8: Transmit done rises when the stop bit begins, and not earlier in the frame.
- R9: A framing 1 reception loads the data byte, copies the stop bit into the received ninth bit and sets receive done.
- R10: A framing 2 or 3 reception loads the data byte and copies the ninth bit into the received ninth bit.
- R11: With the address filter on in framing 2 or 3, a frame whose ninth bit is 0 leaves the receive byte, the received ninth bit and receive done unchanged.
- R12: With receive enable=0, line activity leaves the receive byte and receive done unchanged.
- R13: If `rx_line` is high again at the middle of the start bit, the frame is dropped. The next valid frame is received normally.
- R14: A data write while a transmission is in progress is ignored. The done flags fall only through a control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst | input | 1 | synchronous active-high reset |
| bus_wr | input | 1 | register write strobe |
| bus_sel | input | 1 | 0 selects control byte, 1 selects data |
| bus_wdata | input | 8 | write data |
| bus_rdata | output | 8 | read data for the selected address |
| dbl_rate | input | 1 | doubles the asynchronous bit rate |
| tmr_ovf | input | 1 | timer overflow pulse, one clock wide |
| rx_line | input | 1 | serial input, async line or shift-mode data in |
| tx_line | output | 1 | asynchronous serial output, idle high |
| sclk_o | output | 1 | shift-mode clock, idle high |
| sdat_o | output | 1 | shift-mode data out |
| sdat_oe | output | 1 | shift-mode data drive enable |

## Verification
A bit counter off by one shows up as a lost or extra bit in the frame on `tx_line`, which the next decoded bit exposes. A faulty tick divider stretches every bit, so the mid-bit samples drift into neighbouring bits within a few bits of the frame. On the receive side, a wrong sample point or a broken filter decision shows up in the control and data readback one bit period after the frame ends. Flag timing is read at the middle of the last two bits, so a transmit done raised one bit too early is seen during that frame.

// File: rtl/qsp_pkg.sv
package qsp_pkg;

    typedef enum logic [1:0] {
        SM_SHIFT = 2'd0,
        SM_A8VAR = 2'd1,
        SM_A9FIX = 2'd2,
        SM_A9VAR = 2'd3
    } sp_mode_e;

    typedef struct packed {
        sp_mode_e mode;
        logic     mp_en;
        logic     rx_en;
        logic     tx_b8;
        logic     rx_b8;
        logic     tx_done;
        logic     rx_done;
    } sp_ctl_t;

    localparam int FRAME_W = 11;

    // index 0 is the start bit; the top bit is always a stop level
    function automatic logic [FRAME_W-1:0] frame_of(input logic [7:0] d, input logic b9);
        return {1'b1, b9, d, 1'b0};
    endfunction

    function automatic logic [3:0] last_bit(input sp_mode_e m);
        return (m == SM_A8VAR) ? 4'd9 : 4'd10;
    endfunction

endpackage

// File: rtl/sp_baud.sv
module sp_baud
    import qsp_pkg::*;
#(
    parameter int OVS     = 16,
    parameter int FIX_DIV = 64
) (
    input  logic     clk,
    input  logic     rst,
    input  sp_mode_e mode,
    input  logic     dbl,
    input  logic     ovf,
    output logic     tick
);
    localparam int FIX_TICK = FIX_DIV / OVS;
    localparam int DW       = $clog2(FIX_TICK) + 1;

    logic [DW-1:0] div_q;
    logic          half_q;
    logic [DW-1:0] lim;

    assign lim = dbl ? DW'(FIX_TICK / 2 - 1) : DW'(FIX_TICK - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            half_q <= 1'b0;
        end else begin
            div_q <= (div_q >= lim) ? '0 : div_q + 1'b1;
            if (ovf) half_q <= ~half_q;
        end
    end

    always_comb begin
        if (mode == SM_A9FIX) tick = (div_q == lim);
        else                  tick = ovf && (dbl || half_q);
    end
endmodule

// File: rtl/sp_tx.sv
module sp_tx
    import qsp_pkg::*;
#(
    parameter int SHIFT_DIV = 12,
    parameter int OVS       = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  sp_mode_e   mode,
    input  logic       start,
    input  logic [7:0] data,
    input  logic       b9,
    input  logic       tick,
    output logic       busy,
    output logic       done,
    output logic       line,
    output logic       sclk,
    output logic       sdat,
    output logic       sdat_oe
);
    localparam int CW = $clog2((SHIFT_DIV > OVS) ? SHIFT_DIV : OVS);

    logic [FRAME_W-1:0] frm_q;
    logic [3:0]         idx_q, last_q;
    logic [CW-1:0]      cnt_q;
    logic               sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            sh_q   <= 1'b0;
            idx_q  <= '0;
            last_q <= '0;
            cnt_q  <= '0;
            frm_q  <= '1;
        end else if (start && !busy) begin
            busy  <= 1'b1;
            idx_q <= '0;
            cnt_q <= '0;
            sh_q  <= (mode == SM_SHIFT);
            if (mode == SM_SHIFT) begin
                frm_q  <= {3'b111, data};
                last_q <= 4'd7;
            end else begin
                frm_q  <= frame_of(data, (mode == SM_A8VAR) ? 1'b1 : b9);
                last_q <= last_bit(mode);
            end
        end else if (busy) begin
            if (sh_q || tick) begin
                if (cnt_q == CW'(sh_q ? SHIFT_DIV - 1 : OVS - 1)) begin
                    cnt_q <= '0;
                    if (idx_q == last_q) busy  <= 1'b0;
                    else                 idx_q <= idx_q + 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    always_comb begin
        if (sh_q) done = busy && cnt_q == CW'(SHIFT_DIV - 1) && idx_q == last_q;
        else      done = busy && tick && cnt_q == CW'(OVS - 1) && idx_q == last_q - 4'd1;
    end

    assign line    = (busy && !sh_q) ? frm_q[idx_q] : 1'b1;
    assign sdat    = frm_q[idx_q];
    assign sdat_oe = busy && sh_q;
    assign sclk    = !(busy && sh_q && cnt_q < CW'(SHIFT_DIV / 2));
endmodule

// File: rtl/sp_rx.sv
module sp_rx
    import qsp_pkg::*;
#(
    parameter int SHIFT_DIV = 12,
    parameter int OVS       = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  sp_mode_e   mode,
    input  logic       en,
    input  logic       held,
    input  logic       line,
    input  logic       tick,
    output logic       fin,
    output logic [7:0] data,
    output logic       b9,
    output logic       sclk
);
    localparam int CW = $clog2((SHIFT_DIV > OVS) ? SHIFT_DIV : OVS);

    logic          busy_q, sh_q, prev_q;
    logic [3:0]    idx_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            sh_q   <= 1'b0;
            prev_q <= 1'b1;
            idx_q  <= '0;
            cnt_q  <= '0;
            fin    <= 1'b0;
            data   <= '0;
            b9     <= 1'b0;
        end else begin
            prev_q <= line;
            fin    <= 1'b0;
            if (!en) begin
                busy_q <= 1'b0;
            end else if (!busy_q) begin
                idx_q <= '0;
                cnt_q <= '0;
                if (mode == SM_SHIFT) begin
                    if (!held && !fin) begin
                        busy_q <= 1'b1;
                        sh_q   <= 1'b1;
                    end
                end else if (prev_q && !line) begin
                    busy_q <= 1'b1;
                    sh_q   <= 1'b0;
                end
            end else if (sh_q) begin
                if (cnt_q == CW'(SHIFT_DIV - 1)) begin
                    cnt_q <= '0;
                    data  <= {line, data[7:1]};
                    if (idx_q == 4'd7) begin
                        busy_q <= 1'b0;
                        fin    <= 1'b1;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else if (tick) begin
                if (cnt_q == CW'(OVS / 2 - 1)) begin
                    if (idx_q == 4'd0) begin
                        if (line) busy_q <= 1'b0;
                    end else if (idx_q == 4'd9) begin
                        b9     <= line;
                        busy_q <= 1'b0;
                        fin    <= 1'b1;
                    end else begin
                        data <= {line, data[7:1]};
                    end
                end
                if (cnt_q == CW'(OVS - 1)) begin
                    cnt_q <= '0;
                    idx_q <= idx_q + 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign sclk = !(busy_q && sh_q && cnt_q < CW'(SHIFT_DIV / 2));
endmodule

// File: rtl/quad_serial_port.sv
module quad_serial_port
    import qsp_pkg::*;
#(
    parameter int SHIFT_DIV = 12,
    parameter int OVS       = 16,
    parameter int FIX_DIV   = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic       bus_sel,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       dbl_rate,
    input  logic       tmr_ovf,
    input  logic       rx_line,
    output logic       tx_line,
    output logic       sclk_o,
    output logic       sdat_o,
    output logic       sdat_oe
);
    sp_ctl_t    ctl;
    logic [7:0] rx_buf, ctl_bits, rx_data;
    logic       tick, tx_busy, tx_fin, rx_fin, rx_b9, tx_sclk, rx_sclk;
    logic       accept;

    assign ctl_bits = ctl;

    sp_baud #(.OVS(OVS), .FIX_DIV(FIX_DIV)) u_baud (
        .clk(clk), .rst(rst), .mode(ctl.mode), .dbl(dbl_rate), .ovf(tmr_ovf), .tick(tick)
    );

    sp_tx #(.SHIFT_DIV(SHIFT_DIV), .OVS(OVS)) u_tx (
        .clk(clk), .rst(rst), .mode(ctl.mode), .start(bus_wr && bus_sel),
        .data(bus_wdata), .b9(ctl.tx_b8), .tick(tick), .busy(tx_busy), .done(tx_fin),
        .line(tx_line), .sclk(tx_sclk), .sdat(sdat_o), .sdat_oe(sdat_oe)
    );

    sp_rx #(.SHIFT_DIV(SHIFT_DIV), .OVS(OVS)) u_rx (
        .clk(clk), .rst(rst), .mode(ctl.mode), .en(ctl.rx_en), .held(ctl.rx_done),
        .line(rx_line), .tick(tick), .fin(rx_fin), .data(rx_data), .b9(rx_b9),
        .sclk(rx_sclk)
    );

    // address filter only applies to the eleven-bit framings
    assign accept = (ctl.mode == SM_SHIFT) || !(ctl.mp_en && ctl.mode[1]) || rx_b9;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl    <= '0;
            rx_buf <= '0;
        end else begin
            if (bus_wr && !bus_sel) ctl <= sp_ctl_t'(bus_wdata);
            if (tx_fin) ctl.tx_done <= 1'b1;
            if (rx_fin && accept) begin
                rx_buf      <= rx_data;
                ctl.rx_done <= 1'b1;
                if (ctl.mode != SM_SHIFT) ctl.rx_b8 <= rx_b9;
            end
        end
    end

    assign bus_rdata = bus_sel ? rx_buf : ctl_bits;
    assign sclk_o    = tx_sclk & rx_sclk;
endmodule

// File: rtl/qsp_chk.sv
module qsp_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_wr,
    input logic       bus_sel,
    input logic [7:0] ctl_q,
    input logic       tx_line,
    input logic       sclk_o,
    input logic       sdat_oe,
    input logic       tx_busy
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (tx_line && sclk_o && !sdat_oe && ctl_q == 8'h00));

    // R3
    shift_launch_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sdat_oe) |-> $past(bus_wr && bus_sel));

    // R8
    txdone_at_stop_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(ctl_q[1]) && !$past(bus_wr && !bus_sel)) |-> tx_line);

    // R14
    rxdone_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl_q[0]) |-> $past(bus_wr && !bus_sel));

    // R14
    txdone_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl_q[1]) |-> $past(bus_wr && !bus_sel));

    // R12
    rx_enable_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_q[0]) |-> ($past(ctl_q[4]) || $past(bus_wr && !bus_sel)));

    // R5
    idle_line_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> tx_line);
endmodule

bind quad_serial_port qsp_chk u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_sel(bus_sel), .ctl_q(ctl_bits),
    .tx_line(tx_line), .sclk_o(sclk_o), .sdat_oe(sdat_oe), .tx_busy(tx_busy)
);

// File: tb/quad_serial_port_tb.sv
`timescale 1ns/1ps
module quad_serial_port_tb;
    localparam int OVP = 3;

    logic       clk = 1'b0, rst = 1'b1;
    logic       bus_wr = 1'b0, bus_sel = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       dbl_rate = 1'b0, tmr_ovf = 1'b0, rx_line = 1'b1;
    logic       tx_line, sclk_o, sdat_o, sdat_oe;
    int         n_chk = 0, n_bad = 0, cyc = 0;
    bit         reported = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    quad_serial_port u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .dbl_rate(dbl_rate), .tmr_ovf(tmr_ovf), .rx_line(rx_line),
        .tx_line(tx_line), .sclk_o(sclk_o), .sdat_o(sdat_o), .sdat_oe(sdat_oe)
    );

    initial begin : ovf_gen
        int c = 0;
        forever begin
            @(negedge clk);
            tmr_ovf = (c == 0);
            c = (c == OVP - 1) ? 0 : c + 1;
        end
    end

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        end
    endtask

    task automatic check(input string tag, input logic [10:0] act, input logic [10:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic s, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_sel = s; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic s, output logic [7:0] v);
        bus_sel = s;
        #0.1 v = bus_rdata;
    endtask

    function automatic logic [7:0] ctl_of(input int m, input logic mp, input logic ren,
                                          input logic tb8);
        return {m[1:0], mp, ren, tb8, 3'b000};
    endfunction

    function automatic int bit_clks(input int m, input logic dbl);
        if (m == 2) return dbl ? 32 : 64;
        return OVP * 16 * (dbl ? 1 : 2);
    endfunction

    function automatic logic [10:0] exp_frame(input int m, input logic [7:0] d, input logic b9);
        return {1'b1, (m == 1) ? 1'b1 : b9, d, 1'b0};
    endfunction

    // async transmit: decode the line at bit centres and check flag timing
    task automatic tx_async(input int m, input logic dbl, input logic [7:0] d, input logic b9,
                            input bit poke);
        int          bc = bit_clks(m, dbl);
        int          last = (m == 1) ? 9 : 10;
        logic [10:0] ef = exp_frame(m, d, b9), got = '1;
        logic [7:0]  v;
        dbl_rate = dbl;
        wr(1'b0, ctl_of(m, 1'b0, 1'b0, b9));
        wr(1'b1, d);
        if (poke) wr(1'b1, ~d);   // R14: ignored while busy
        repeat (bc / 2 - (poke ? 2 : 0)) @(negedge clk);
        for (int i = 0; i <= last; i++) begin
            got[i] = tx_line;
            rd(1'b0, v);
            if (i == last - 1) check("R8 done early", 11'(v[1]), 11'd0);
            if (i == last)     check("R8 done at stop", 11'(v[1]), 11'd1);
            repeat (bc) @(negedge clk);
        end
        check(m == 1 ? "R5/R7 frame" : "R6/R7 frame", got, ef);
        check("R5 idle", 11'(tx_line), 11'd1);
    endtask

    task automatic rx_drive(input int m, input int bc, input logic [7:0] d, input logic b9);
        logic [10:0] f = exp_frame(m, d, b9);
        int          nb = (m == 1) ? 10 : 11;
        for (int i = 0; i < nb; i++) begin
            rx_line = f[i];
            repeat (bc) @(negedge clk);
        end
        rx_line = 1'b1;
        repeat (bc) @(negedge clk);
    endtask

    task automatic rx_async(input int m, input logic dbl, input logic mp, input logic ren,
                            input logic [7:0] d, input logic b9, input string tag);
        int         bc = bit_clks(m, dbl);
        logic [7:0] v, prev_buf, prev_ctl;
        bit         take;
        dbl_rate = dbl;
        wr(1'b0, ctl_of(m, mp, ren, 1'b0));
        rd(1'b1, prev_buf);
        rd(1'b0, prev_ctl);
        rx_drive(m, bc, d, b9);
        take = ren && !(mp && m >= 2 && !b9);
        rd(1'b0, v);
        check({tag, " done"}, 11'(v[0]), take ? 11'd1 : 11'd0);
        check({tag, " ninth"}, 11'(v[2]), take ? ((m == 1) ? 11'd1 : 11'(b9)) : 11'(prev_ctl[2]));
        rd(1'b1, v);
        check({tag, " data"}, 11'(v), take ? 11'(d) : 11'(prev_buf));
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        report();
        $finish;
    end

    initial begin : main
        logic [7:0]  v, d;
        logic [7:0]  got;
        int          ts[8];
        void'($urandom(32'h5eed_1234));
        repeat (4) @(negedge clk);
        rd(1'b0, v); check("R1 ctl in reset", 11'(v), 11'h000);
        rst = 1'b0;
        @(negedge clk);
        rd(1'b0, v); check("R1 ctl", 11'(v), 11'h000);
        rd(1'b1, v); check("R1 rx byte", 11'(v), 11'h000);
        check("R1 lines", {8'h0, tx_line, sclk_o, sdat_oe}, 11'b110);

        // R2 field readback
        wr(1'b0, 8'hb8);
        rd(1'b0, v); check("R2 ctl fields", 11'(v), 11'h0b8);

        // R3 shift-mode transmit
        for (int k = 0; k < 3; k++) begin
            d = (k == 0) ? 8'ha5 : 8'($urandom);
            wr(1'b0, ctl_of(0, 1'b0, 1'b0, 1'b0));
            wr(1'b1, d);
            for (int b = 0; b < 8; b++) begin
                while (sclk_o) @(negedge clk);
                while (!sclk_o) @(negedge clk);
                got[b] = sdat_o; ts[b] = cyc;
            end
            check("R3 shift bits", 11'(got), 11'(d));
            check("R3 bit period", 11'(ts[7] - ts[0]), 11'd84);
            repeat (20) @(negedge clk);
            rd(1'b0, v);
            check("R3 done", 11'(v[1]), 11'd1);
            check("R3 oe off", 11'(sdat_oe), 11'd0);
        end

        // R4 shift-mode receive
        for (int k = 0; k < 3; k++) begin
            d = (k == 0) ? 8'h3c : 8'($urandom);
            wr(1'b0, ctl_of(0, 1'b0, 1'b1, 1'b0));
            for (int b = 0; b < 8; b++) begin
                while (sclk_o) @(negedge clk);
                rx_line = d[b];
                while (!sclk_o) @(negedge clk);
            end
            repeat (20) @(negedge clk);
            rx_line = 1'b1;
            rd(1'b0, v); check("R4 done", 11'(v[0]), 11'd1);
            rd(1'b1, v); check("R4 data", 11'(v), 11'(d));
            wr(1'b0, ctl_of(0, 1'b0, 1'b0, 1'b0));
        end

        // asynchronous transmit, directed and random
        tx_async(1, 1'b0, 8'h00, 1'b0, 0);
        tx_async(2, 1'b0, 8'hff, 1'b0, 1);
        tx_async(2, 1'b1, 8'h81, 1'b1, 0);
        tx_async(3, 1'b1, 8'h5a, 1'b1, 1);
        for (int k = 0; k < 6; k++)
            tx_async(1 + (k % 3), 1'($urandom), 8'($urandom), 1'($urandom), 0);

        // asynchronous receive
        rx_async(1, 1'b0, 1'b0, 1'b1, 8'hc3, 1'b0, "R9");
        rx_async(2, 1'b0, 1'b0, 1'b1, 8'h7e, 1'b1, "R10");
        rx_async(3, 1'b1, 1'b0, 1'b1, 8'h19, 1'b0, "R10");
        for (int k = 0; k < 5; k++)
            rx_async(1 + (k % 3), 1'($urandom), 1'b0, 1'b1, 8'($urandom), 1'($urandom), "R9/R10");
        rx_async(2, 1'b0, 1'b1, 1'b1, 8'h44, 1'b0, "R11 filtered");
        rx_async(3, 1'b0, 1'b1, 1'b1, 8'h99, 1'b0, "R11 filtered");
        rx_async(2, 1'b1, 1'b1, 1'b1, 8'he7, 1'b1, "R11 address");
        rx_async(1, 1'b1, 1'b0, 1'b0, 8'h12, 1'b0, "R12 disabled");

        // R13 false start followed by a good frame
        dbl_rate = 1'b0;
        wr(1'b0, ctl_of(2, 1'b0, 1'b1, 1'b0));
        rx_line = 1'b0;
        repeat (12) @(negedge clk);
        rx_line = 1'b1;
        repeat (128) @(negedge clk);
        rd(1'b0, v); check("R13 glitch ignored", 11'(v[0]), 11'd0);
        rx_drive(2, 64, 8'hb6, 1'b1);
        rd(1'b1, v); check("R13 next frame", 11'(v), 11'h0b6);
        rd(1'b0, v); check("R13 next done", 11'(v[0]), 11'd1);

        // R14 flags sticky until a control write
        repeat (50) @(negedge clk);
        rd(1'b0, v); check("R14 held", 11'(v[0]), 11'd1);
        wr(1'b0, ctl_of(2, 1'b0, 1'b0, 1'b0));
        rd(1'b0, v); check("R14 cleared", 11'(v[1:0]), 11'd0);

        report();
        $finish;
    end
endmodule